// File: doc/BRIEF.md
# Pipelined split-tree packet classifier

This block sorts packet headers into rules by walking a binary split tree that is unrolled into a linear pipeline. Each tree level belongs to one stage, and each stage holds the nodes of its level in a private node table. A header key made of several fields enters with a valid flag. Every clock it moves one stage down the tree. A fixed number of cycles later it leaves with either a rule number or a no-match indication.

A table entry takes one of four forms:

- A plain node compares one chosen header field against a split value and picks one of two children.
- A merged node folds two tree levels into one entry. It holds three field/value pairs and picks one of four children.
- A leaf holds a rule number.
- An empty entry ends the search without a match.

Leaves may sit in any stage. A key that has already reached a leaf rides through the remaining stages with its result unchanged. Two independent search lanes read every table in the same clock. Each table has its own write port, which the control plane uses to load or patch the tree.

Top module: `split_tree_classifier`

## Requirements
- R1: Every search starts at address 0 of the stage-0 table. A key accepted on a clock edge (key_vld high) produces res_vld on that lane exactly NUM_STAGES+1 edges later, which is 5 with the defaults. Keys may be accepted on every cycle.
- R2: A plain node selects header field number sel1, taken from key bits [sel1*FIELD_W +: FIELD_W] with field 0 at the least significant end. If the field is less than or equal to val1, the search continues at address base of the next stage. If the field is greater, it continues at base+1.
- R3: A merged node first computes b1, which is 1 when field sel1 is greater than val1. When b1 is 0 it tests field sel2 against val2; when b1 is 1 it tests field sel3 against val3. That second test gives b2. The next address is base + 2*b1 + b2.
- R4: A leaf in any stage resolves the search with a hit and the leaf's rule number. That result is carried unchanged through all later stages.
- R5: An empty entry resolves the search as a miss. A miss is reported as res_vld=1, res_hit=0 and res_rule=0, and it is also carried unchanged to the output.
- R6: A search that is still at a plain or merged node after the last stage is reported as a miss.
- R7: The two lanes search independently in the same cycle, using the same tables. Each lane's result depends only on that lane's key.
- R8: A table write on a clock edge is seen by every read of that stage on a later edge. A search that starts after the write therefore uses the new entry.
- R9: After reset, res_vld is 0. Whenever res_vld of a lane is 0, that lane's res_hit and res_rule are 0.
- R10: The entry layout is as follows:
  - bits [1:0] hold the kind: 00 plain, 01 merged, 10 leaf, 11 empty;
  - bits [AW+1:2] hold the child base address;
  - the next RULE_W bits hold the rule number;
  - the next three groups of SEL_W bits hold sel1, sel2 and sel3 in that order;
  - the top three groups of FIELD_W bits hold val1, val2 and val3 in that order.

  With the defaults (AW=8, RULE_W=12, SEL_W=3, FIELD_W=32) this gives base [9:2], rule [21:10], sel1 [24:22], sel2 [27:25], sel3 [30:28], val1 [62:31], val2 [94:63] and val3 [126:95].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wen | input | NUM_STAGES | Write enable, one bit per stage table |
| tbl_addr | input | NUM_STAGES*AW | Write address, AW bits per stage, stage 0 lowest |
| tbl_data | input | NUM_STAGES*NODE_W | Entry to write, NODE_W bits per stage, stage 0 lowest |
| key_vld | input | LANES | Key valid, one bit per lane |
| key_in | input | LANES*NUM_FIELDS*FIELD_W | Header keys, lane 0 lowest |
| res_vld | output | LANES | Result valid per lane |
| res_hit | output | LANES | Rule matched per lane |
| res_rule | output | LANES*RULE_W | Matched rule number per lane, 0 on a miss |

## Verification
The hardest cases to produce from the ports are these:

- a search that resolves at a leaf early while the other lane is still deep in the tree;
- a search that runs off the end of the pipeline while still sitting on an interior node;
- the choice between the second and third pair of a merged node.

The stimulus builds a small tree through the write ports. It then sends keys that sit exactly on each split value and keys whose unused pair would steer the other way. It also patches entries so that a leaf sits at the root and an interior node sits in the last stage. Long runs of random keys on both lanes in the same cycles are then compared cycle by cycle against a behavioural walk of the bench's own copy of the tables.

// File: rtl/tcls_pkg.sv
package tcls_pkg;

  typedef enum logic [1:0] {
    NK_PLAIN  = 2'b00,
    NK_MERGED = 2'b01,
    NK_LEAF   = 2'b10,
    NK_EMPTY  = 2'b11
  } node_kind_e;

  function automatic int sel_width(input int nf);
    return (nf > 1) ? $clog2(nf) : 1;
  endfunction

  // kind + base + rule + three selectors + three split values
  function automatic int node_width(input int nf, input int fw, input int aw, input int rw);
    return 2 + aw + rw + 3 * sel_width(nf) + 3 * fw;
  endfunction

endpackage

// File: rtl/tcls_node_eval.sv
module tcls_node_eval
  import tcls_pkg::*;
#(
  parameter  int NUM_FIELDS = 5,
  parameter  int FIELD_W    = 32,
  parameter  int AW         = 8,
  parameter  int RULE_W     = 12,
  localparam int KEY_W      = NUM_FIELDS * FIELD_W,
  localparam int NODE_W     = node_width(NUM_FIELDS, FIELD_W, AW, RULE_W)
) (
  input  logic              in_res,
  input  logic              in_hit,
  input  logic [RULE_W-1:0] in_rule,
  input  logic [KEY_W-1:0]  key,
  input  logic [NODE_W-1:0] node,
  output logic              nx_res,
  output logic              nx_hit,
  output logic [RULE_W-1:0] nx_rule,
  output logic [AW-1:0]     nx_addr
);

  localparam int SEL_W    = sel_width(NUM_FIELDS);
  localparam int BASE_LSB = 2;
  localparam int RULE_LSB = BASE_LSB + AW;
  localparam int SEL_LSB  = RULE_LSB + RULE_W;
  localparam int VAL_LSB  = SEL_LSB + 3 * SEL_W;

  function automatic logic [FIELD_W-1:0] pick_field(input logic [KEY_W-1:0] k,
                                                    input logic [SEL_W-1:0] s);
    pick_field = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (s == SEL_W'(i)) pick_field = k[i*FIELD_W +: FIELD_W];
  endfunction

  node_kind_e          kind;
  logic [AW-1:0]       base;
  logic [SEL_W-1:0]    sel [3];
  logic [FIELD_W-1:0]  val [3];
  logic                b1, b2;

  assign kind = node_kind_e'(node[1:0]);
  assign base = node[BASE_LSB +: AW];

  for (genvar p = 0; p < 3; p++) begin : g_pair
    assign sel[p] = node[SEL_LSB + p*SEL_W +: SEL_W];
    assign val[p] = node[VAL_LSB + p*FIELD_W +: FIELD_W];
  end

  always_comb begin
    b1 = pick_field(key, sel[0]) > val[0];
    // first outcome chooses which pair drives the second test
    if (b1) b2 = pick_field(key, sel[2]) > val[2];
    else    b2 = pick_field(key, sel[1]) > val[1];
  end

  always_comb begin
    nx_res  = in_res;
    nx_hit  = in_hit;
    nx_rule = in_rule;
    nx_addr = '0;
    if (!in_res) begin
      case (kind)
        NK_PLAIN:  nx_addr = base + AW'(b1);
        NK_MERGED: nx_addr = base + AW'({b1, b2});
        NK_LEAF: begin
          nx_res  = 1'b1;
          nx_hit  = 1'b1;
          nx_rule = node[RULE_LSB +: RULE_W];
        end
        default: begin
          nx_res  = 1'b1;
          nx_hit  = 1'b0;
          nx_rule = '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/tcls_stage.sv
module tcls_stage
  import tcls_pkg::*;
#(
  parameter  int NUM_FIELDS = 5,
  parameter  int FIELD_W    = 32,
  parameter  int AW         = 8,
  parameter  int RULE_W     = 12,
  parameter  int LANES      = 2,
  localparam int KEY_W      = NUM_FIELDS * FIELD_W,
  localparam int NODE_W     = node_width(NUM_FIELDS, FIELD_W, AW, RULE_W),
  localparam int DEPTH      = 1 << AW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [NODE_W-1:0]       wr_data,
  input  logic [LANES-1:0]        in_vld,
  input  logic [LANES*KEY_W-1:0]  in_key,
  input  logic [LANES*AW-1:0]     in_addr,
  input  logic [LANES-1:0]        in_res,
  input  logic [LANES-1:0]        in_hit,
  input  logic [LANES*RULE_W-1:0] in_rule,
  output logic [LANES-1:0]        out_vld,
  output logic [LANES*KEY_W-1:0]  out_key,
  output logic [LANES*AW-1:0]     out_addr,
  output logic [LANES-1:0]        out_res,
  output logic [LANES-1:0]        out_hit,
  output logic [LANES*RULE_W-1:0] out_rule
);

  logic [NODE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic              vld_q, res_q, hit_q, rd_en;
    logic [KEY_W-1:0]  key_q;
    logic [RULE_W-1:0] rule_q;
    logic [NODE_W-1:0] node_q;

    assign rd_en = in_vld[l] & ~in_res[l];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= in_vld[l];
    end

    always_ff @(posedge clk) begin
      if (in_vld[l]) begin
        key_q  <= in_key[l*KEY_W +: KEY_W];
        res_q  <= in_res[l];
        hit_q  <= in_hit[l];
        rule_q <= in_rule[l*RULE_W +: RULE_W];
      end
    end

    always_ff @(posedge clk) begin
      if (rd_en) node_q <= mem[in_addr[l*AW +: AW]];
    end

    tcls_node_eval #(
      .NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .AW(AW), .RULE_W(RULE_W)
    ) u_eval (
      .in_res (res_q),
      .in_hit (hit_q),
      .in_rule(rule_q),
      .key    (key_q),
      .node   (node_q),
      .nx_res (out_res[l]),
      .nx_hit (out_hit[l]),
      .nx_rule(out_rule[l*RULE_W +: RULE_W]),
      .nx_addr(out_addr[l*AW +: AW])
    );

    assign out_vld[l]                 = vld_q;
    assign out_key[l*KEY_W +: KEY_W]  = key_q;
  end

endmodule

// File: rtl/split_tree_classifier.sv
module split_tree_classifier
  import tcls_pkg::*;
#(
  parameter  int NUM_STAGES = 4,
  parameter  int NUM_FIELDS = 5,
  parameter  int FIELD_W    = 32,
  parameter  int AW         = 8,
  parameter  int RULE_W     = 12,
  parameter  int LANES      = 2,
  localparam int KEY_W      = NUM_FIELDS * FIELD_W,
  localparam int NODE_W     = node_width(NUM_FIELDS, FIELD_W, AW, RULE_W)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_STAGES-1:0]        tbl_wen,
  input  logic [NUM_STAGES*AW-1:0]     tbl_addr,
  input  logic [NUM_STAGES*NODE_W-1:0] tbl_data,
  input  logic [LANES-1:0]             key_vld,
  input  logic [LANES*KEY_W-1:0]       key_in,
  output logic [LANES-1:0]             res_vld,
  output logic [LANES-1:0]             res_hit,
  output logic [LANES*RULE_W-1:0]      res_rule
);

  logic [LANES-1:0]        c_vld  [NUM_STAGES+1];
  logic [LANES-1:0]        c_res  [NUM_STAGES+1];
  logic [LANES-1:0]        c_hit  [NUM_STAGES+1];
  logic [LANES*KEY_W-1:0]  c_key  [NUM_STAGES+1];
  logic [LANES*AW-1:0]     c_addr [NUM_STAGES+1];
  logic [LANES*RULE_W-1:0] c_rule [NUM_STAGES+1];

  // every search enters at the root, address 0 of stage 0
  assign c_vld[0]  = key_vld;
  assign c_key[0]  = key_in;
  assign c_addr[0] = '0;
  assign c_res[0]  = '0;
  assign c_hit[0]  = '0;
  assign c_rule[0] = '0;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    tcls_stage #(
      .NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .AW(AW),
      .RULE_W(RULE_W), .LANES(LANES)
    ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_wen[s]),
      .wr_addr (tbl_addr[s*AW +: AW]),
      .wr_data (tbl_data[s*NODE_W +: NODE_W]),
      .in_vld  (c_vld[s]),
      .in_key  (c_key[s]),
      .in_addr (c_addr[s]),
      .in_res  (c_res[s]),
      .in_hit  (c_hit[s]),
      .in_rule (c_rule[s]),
      .out_vld (c_vld[s+1]),
      .out_key (c_key[s+1]),
      .out_addr(c_addr[s+1]),
      .out_res (c_res[s+1]),
      .out_hit (c_hit[s+1]),
      .out_rule(c_rule[s+1])
    );
  end

  logic tail_unused;
  assign tail_unused = ^{c_key[NUM_STAGES], c_addr[NUM_STAGES]};

  logic [LANES-1:0]        hit_nx;
  logic [LANES*RULE_W-1:0] rule_nx;

  // unresolved after the last stage counts as a miss
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      hit_nx[l] = c_vld[NUM_STAGES][l] & c_res[NUM_STAGES][l] & c_hit[NUM_STAGES][l];
      rule_nx[l*RULE_W +: RULE_W] = hit_nx[l] ? c_rule[NUM_STAGES][l*RULE_W +: RULE_W] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld  <= '0;
      res_hit  <= '0;
      res_rule <= '0;
    end else begin
      res_vld  <= c_vld[NUM_STAGES];
      res_hit  <= hit_nx;
      res_rule <= rule_nx;
    end
  end

endmodule

// File: rtl/tcls_checker.sv
module tcls_checker #(
  parameter int NUM_STAGES = 4,
  parameter int RULE_W     = 12,
  parameter int LANES      = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LANES-1:0]        key_vld,
  input logic [NUM_STAGES-1:0]   tbl_wen,
  input logic [LANES-1:0]        res_vld,
  input logic [LANES-1:0]        res_hit,
  input logic [LANES*RULE_W-1:0] res_rule
);

  localparam int LAT = NUM_STAGES + 1;

  logic [LANES-1:0] vpipe [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) vpipe[i] <= '0;
    end else begin
      vpipe[0] <= key_vld;
      for (int i = 1; i < LAT; i++) vpipe[i] <= vpipe[i-1];
    end
  end

  // R9
  res_vld_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(res_vld) && !$isunknown(tbl_wen));

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    // R1
    fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld[l] == vpipe[LAT-1][l]);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_vld[l] |-> (!res_hit[l] && res_rule[l*RULE_W +: RULE_W] == '0));

    // R5
    miss_rule_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld[l] && !res_hit[l]) |-> res_rule[l*RULE_W +: RULE_W] == '0);
  end

endmodule

bind split_tree_classifier tcls_checker #(
  .NUM_STAGES(NUM_STAGES), .RULE_W(RULE_W), .LANES(LANES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .key_vld (key_vld),
  .tbl_wen (tbl_wen),
  .res_vld (res_vld),
  .res_hit (res_hit),
  .res_rule(res_rule)
);

// File: tb/sim_split_tree_classifier.sv
`timescale 1ns/1ps
module sim_split_tree_classifier;

  localparam int NS    = 4;
  localparam int FW    = 32;
  localparam int AW    = 8;
  localparam int RW    = 12;
  localparam int LN    = 2;
  localparam int KEYW  = 5 * FW;
  localparam int NODEW = 127;
  localparam int LAT   = NS + 1;

  logic                  clk, rst_n;
  logic [NS-1:0]         tbl_wen;
  logic [NS*AW-1:0]      tbl_addr;
  logic [NS*NODEW-1:0]   tbl_data;
  logic [LN-1:0]         key_vld;
  logic [LN*KEYW-1:0]    key_in;
  logic [LN-1:0]         res_vld, res_hit;
  logic [LN*RW-1:0]      res_rule;

  split_tree_classifier u0 (
    .clk(clk), .rst_n(rst_n), .tbl_wen(tbl_wen), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .key_vld(key_vld), .key_in(key_in),
    .res_vld(res_vld), .res_hit(res_hit), .res_rule(res_rule)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;

  // bench copy of the tables
  int          m_kind [NS][256];
  int          m_base [NS][256];
  int          m_rule [NS][256];
  int          m_sel  [NS][256][3];
  logic [31:0] m_val  [NS][256][3];

  int    exp_q   [LN][$];
  int    stamp_q [LN][$];
  string tag_q   [LN][$];

  function automatic logic [31:0] fld(input logic [KEYW-1:0] k, input int s);
    return k[s*FW +: FW];
  endfunction

  function automatic logic [KEYW-1:0] mk_key(input logic [31:0] f0, f1, f2, f3, f4);
    return {f4, f3, f2, f1, f0};
  endfunction

  // -1 means no match
  function automatic int ref_walk(input logic [KEYW-1:0] k);
    int a = 0;
    logic b1, b2;
    for (int s = 0; s < NS; s++) begin
      case (m_kind[s][a])
        0: begin
          b1 = fld(k, m_sel[s][a][0]) > m_val[s][a][0];
          a  = (m_base[s][a] + int'(b1)) % 256;
        end
        1: begin
          b1 = fld(k, m_sel[s][a][0]) > m_val[s][a][0];
          if (b1) b2 = fld(k, m_sel[s][a][2]) > m_val[s][a][2];
          else    b2 = fld(k, m_sel[s][a][1]) > m_val[s][a][1];
          a = (m_base[s][a] + 2 * int'(b1) + int'(b2)) % 256;
        end
        2:       return m_rule[s][a];
        default: return -1;
      endcase
    end
    return -1;
  endfunction

  task automatic check_outs();
    for (int l = 0; l < LN; l++) begin
      int got;
      logic [RW-1:0] r;
      r = res_rule[l*RW +: RW];
      if (res_vld[l] === 1'b1) begin
        got = res_hit[l] ? int'(r) : -1;
        checks++;
        if (exp_q[l].size() == 0) begin
          fails++;
          $display("FAIL R1 lane %0d: unexpected result act=%0d exp=none", l, got);
        end else begin
          int e, st;
          string t;
          e = exp_q[l].pop_front();
          st = stamp_q[l].pop_front();
          t = tag_q[l].pop_front();
          if (cyc - st != LAT) begin
            fails++;
            $display("FAIL R1 lane %0d: latency act=%0d exp=%0d", l, cyc - st, LAT);
          end
          if (got != e || (!res_hit[l] && r != 0)) begin
            fails++;
            $display("FAIL %s lane %0d: act=%0d (rule %0d) exp=%0d", t, l, got, r, e);
          end
        end
      end else begin
        checks++;
        if (res_hit[l] !== 1'b0 || r !== '0) begin
          fails++;
          $display("FAIL R9 lane %0d: idle outputs act=%0b/%0d exp=0/0", l, res_hit[l], r);
        end
        if (stamp_q[l].size() > 0 && stamp_q[l][0] + LAT <= cyc) begin
          fails++;
          $display("FAIL R1 lane %0d: missing result act=none exp=%0d", l, exp_q[l][0]);
          void'(exp_q[l].pop_front());
          void'(stamp_q[l].pop_front());
          void'(tag_q[l].pop_front());
        end
      end
    end
  endtask

  task automatic lookup(input logic v0, input logic [KEYW-1:0] k0, input string t0,
                        input logic v1, input logic [KEYW-1:0] k1, input string t1);
    @(negedge clk);
    check_outs();
    tbl_wen = '0;
    key_vld = {v1, v0};
    key_in  = {k1, k0};
    if (v0) begin exp_q[0].push_back(ref_walk(k0)); stamp_q[0].push_back(cyc); tag_q[0].push_back(t0); end
    if (v1) begin exp_q[1].push_back(ref_walk(k1)); stamp_q[1].push_back(cyc); tag_q[1].push_back(t1); end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) lookup(1'b0, '0, "", 1'b0, '0, "");
  endtask

  // entry layout per R10
  task automatic wr_node(input int s, input int a, input int kind, input int base,
                         input int rule, input int s1, input logic [31:0] v1,
                         input int s2, input logic [31:0] v2,
                         input int s3, input logic [31:0] v3);
    logic [NODEW-1:0] n;
    n = '0;
    n[1:0]    = 2'(kind);
    n[9:2]    = 8'(base);
    n[21:10]  = 12'(rule);
    n[24:22]  = 3'(s1);
    n[27:25]  = 3'(s2);
    n[30:28]  = 3'(s3);
    n[62:31]  = v1;
    n[94:63]  = v2;
    n[126:95] = v3;
    @(negedge clk);
    check_outs();
    key_vld = '0;
    tbl_wen = '0;
    tbl_wen[s] = 1'b1;
    tbl_addr[s*AW +: AW] = 8'(a);
    tbl_data[s*NODEW +: NODEW] = n;
    m_kind[s][a] = kind; m_base[s][a] = base; m_rule[s][a] = rule;
    m_sel[s][a][0] = s1; m_sel[s][a][1] = s2; m_sel[s][a][2] = s3;
    m_val[s][a][0] = v1; m_val[s][a][1] = v2; m_val[s][a][2] = v3;
  endtask

  task automatic expect_now(input int lane, input int e, input string t);
    // direct literal check of the bench model against the requirement
    checks++;
    if (exp_q[lane][exp_q[lane].size()-1] != e) begin
      fails++;
      $display("FAIL %s model lane %0d: act=%0d exp=%0d", t, lane,
               exp_q[lane][exp_q[lane].size()-1], e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++)
      for (int a = 0; a < 256; a++) begin
        m_kind[s][a] = 3; m_base[s][a] = 0; m_rule[s][a] = 0;
        for (int p = 0; p < 3; p++) begin m_sel[s][a][p] = 0; m_val[s][a][p] = '0; end
      end
    rst_n = 1'b0; tbl_wen = '0; tbl_addr = '0; tbl_data = '0; key_vld = '0; key_in = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    checks++;
    if (res_vld !== '0 || res_hit !== '0 || res_rule !== '0) begin
      fails++;
      $display("FAIL R9 reset: act=%0b/%0b/%0h exp=0/0/0", res_vld, res_hit, res_rule);
    end
    rst_n = 1'b1;

    // tree: root splits f0 at 100; lower side a merged node; upper side a leaf
    wr_node(0, 0, 0, 0, 0, 0, 100, 0, 0, 0, 0);
    wr_node(1, 0, 1, 4, 0, 1, 50, 2, 10, 3, 20);
    wr_node(1, 1, 2, 0, 7, 0, 0, 0, 0, 0, 0);
    wr_node(2, 4, 2, 0, 1, 0, 0, 0, 0, 0, 0);
    wr_node(2, 5, 2, 0, 2, 0, 0, 0, 0, 0, 0);
    wr_node(2, 6, 0, 2, 0, 4, 1000, 0, 0, 0, 0);
    wr_node(2, 7, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    wr_node(3, 2, 2, 0, 3, 0, 0, 0, 0, 0, 0);
    wr_node(3, 3, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(2);

    // R4 early leaf on lane 0 alongside a deep search on lane 1 (R7)
    lookup(1, mk_key(150, 0, 0, 0, 0), "R4", 1, mk_key(100, 51, 0, 20, 1000), "R2");
    expect_now(0, 7, "R4"); expect_now(1, 3, "R2");
    // R2 equality takes lower branch; R3 b1=0,b2=0
    lookup(1, mk_key(100, 50, 10, 0, 0), "R3", 1, mk_key(101, 0, 0, 0, 0), "R2");
    expect_now(0, 1, "R3"); expect_now(1, 7, "R2");
    // R3 b1=0,b2=1
    lookup(1, mk_key(0, 50, 11, 0, 0), "R3", 0, '0, "");
    expect_now(0, 2, "R3");
    // R3 pair choice: pair2 would go upper, pair3 must decide
    lookup(1, mk_key(0, 51, 999, 0, 1000), "R3", 1, mk_key(0, 51, 0, 21, 0), "R5");
    expect_now(0, 3, "R3"); expect_now(1, -1, "R5");
    // R5 empty leaf in last stage
    lookup(1, mk_key(0, 51, 0, 0, 1001), "R5", 1, mk_key(0, 51, 0, 0, 1001), "R7");
    expect_now(0, -1, "R5");
    idle(8);

    // R7 random keys on both lanes
    for (int i = 0; i < 300; i++) begin
      logic v0, v1;
      logic [KEYW-1:0] k0, k1;
      v0 = ($urandom_range(0, 3) != 0);
      v1 = ($urandom_range(0, 3) != 0);
      k0 = mk_key($urandom_range(98, 102), $urandom_range(48, 53), $urandom_range(8, 12),
                  $urandom_range(18, 22), $urandom_range(998, 1003));
      k1 = mk_key($urandom_range(98, 102), $urandom_range(48, 53), $urandom_range(8, 12),
                  $urandom_range(18, 22), $urandom_range(998, 1003));
      lookup(v0, k0, "R7", v1, k1, "R7");
    end
    idle(8);

    // R6 interior node in the last stage leaves the search unresolved
    wr_node(3, 3, 0, 0, 0, 0, 5, 0, 0, 0, 0);
    lookup(1, mk_key(0, 51, 0, 0, 1001), "R6", 1, mk_key(0, 51, 0, 0, 1000), "R6");
    expect_now(0, -1, "R6"); expect_now(1, 3, "R6");
    idle(8);

    // R8 root becomes a leaf; search on the very next cycle sees it (R4 carried 3 stages)
    wr_node(0, 0, 2, 0, 9, 0, 0, 0, 0, 0, 0);
    lookup(1, mk_key(0, 0, 0, 0, 0), "R8", 1, mk_key(500, 0, 0, 0, 0), "R8");
    expect_now(0, 9, "R8"); expect_now(1, 9, "R8");
    idle(8);
    wr_node(0, 0, 0, 0, 0, 0, 100, 0, 0, 0, 0);
    wr_node(3, 2, 2, 0, 11, 0, 0, 0, 0, 0, 0);
    lookup(1, mk_key(0, 51, 0, 0, 1000), "R8", 1, mk_key(200, 0, 0, 0, 0), "R8");
    expect_now(0, 11, "R8"); expect_now(1, 7, "R8");
    idle(10);

    for (int l = 0; l < LN; l++) begin
      checks++;
      if (exp_q[l].size() != 0) begin
        fails++;
        $display("FAIL R1 lane %0d: pending act=%0d exp=0", l, exp_q[l].size());
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule